// File: doc/BRIEF.md
# Microprogrammed Sum-Times-Scale Unit

This unit evaluates `E*(A+B)` for 8-bit unsigned operands with a deliberately small datapath: two operand registers for the addends, one register for the scale factor, a single adder, a single multiplier and one shared result register. A two-way selector picks whether the adder or the multiplier writes the shared register. The register holds the sum first and the product after that. The datapath has no hard-wired state machine. A control store sequences it. Each stored word holds eight control bits and a four-bit successor address, and a program counter simply follows those successor addresses.

An operation starts with a valid/ready handshake on the operand side. The unit accepts a triple only while it rests at its idle word, and it captures all three operands at the accepting edge. The caller may then change or withdraw the inputs. The result side has no back-pressure: `out_valid` is a single-cycle pulse, and the caller must take `out_result` in that cycle. The result register keeps the product until the next operation overwrites it. The idle word points to itself, so the unit waits there until another handshake happens.

Top module: `ucsm_top`

## Requirements
- R1: A synchronous active-high reset puts the unit in the idle state. After reset, `in_ready` is 1, `out_valid` is 0 and `out_result` is 0.
- R2: `in_ready` is 1 only in the idle state. It drops on the edge that accepts a triple. While `in_ready` is 0, `in_valid` and the operand inputs have no effect on the result.
- R3: Each accepted triple produces exactly one `out_valid` pulse. The pulse is one cycle wide. It starts on the fourth rising edge after the accepting edge.
- R4: While `out_valid` is 1, `out_result` equals `E*(A+B)` as a 17-bit unsigned value with no truncation. For example, 255, 255 and 255 give 130050.
- R5: Operands are taken at the accepting edge. Changing `in_a`, `in_b` or `in_e` after that edge does not change the result.
- R6: The cycle after `out_valid` is 1, the unit is idle again with `in_ready` = 1, so back-to-back operations are possible.
- R7: While the unit is idle and `in_valid` is 0, `out_valid` stays 0.
- R8: While the unit is idle and `in_valid` is 0, `out_result` holds its last value.
- R9: The shared register is visible on `out_result`. On the second rising edge after acceptance it takes the 9-bit sum `A+B`, zero-extended, before the product overwrites it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand triple offered |
| in_ready | output | 1 | Unit idle; a triple is accepted this cycle if `in_valid` is 1 |
| in_a | input | 8 | First addend |
| in_b | input | 8 | Second addend |
| in_e | input | 8 | Scale factor |
| out_valid | output | 1 | One-cycle pulse marking a finished product |
| out_result | output | 17 | Shared result register |

## Verification
The bench targets four kinds of error.
- **Carry out of the addition.** Cases such as 200+100 and the all-255 triple catch a sum or a product that loses its top bit. Such a design returns a value a multiple of 256 or 65536 too small.
- **Timing of the done pulse.** The bench checks the exact cycle of the pulse and that it is one cycle wide. A microprogram with a wrong successor address, or a done bit in the wrong word, shows up as an early, late, doubled or missing pulse.
- **Operand capture.** The bench scrambles the operands and keeps `in_valid` high during the busy cycles. A unit that reads live inputs, or that restarts mid-sequence, then produces a wrong product.
- **Idle behaviour.** Idle stretches are checked for a result that drifts and for a spurious pulse.

// File: rtl/ucsm_pkg.sv
package ucsm_pkg;
  localparam int AW = 4;
  localparam logic [AW-1:0] IDLE_ADDR  = '1;
  localparam logic [AW-1:0] ENTRY_ADDR = '0;

  // control bits, most significant first
  typedef struct packed {
    logic ld_r1;
    logic ld_r2;
    logic ld_r3;
    logic ld_r4;
    logic sel_add;  // 1: adder feeds R3, 0: multiplier feeds R3
    logic add_en;
    logic mul_en;
    logic done;
  } ctl_t;

  typedef struct packed {
    ctl_t            ctl;
    logic [AW-1:0]   nxt;
  } uword_t;
endpackage

// File: rtl/ucsm_rom.sv
module ucsm_rom
  import ucsm_pkg::*;
(
  input  logic [AW-1:0] addr,
  output uword_t        word
);
  always_comb begin
    case (addr)
      4'd0:    word = {8'b1100_0000, 4'd1};  // capture addends
      4'd1:    word = {8'b0010_1100, 4'd2};  // R3 <= R1 + R2
      4'd2:    word = {8'b0001_0000, 4'd3};  // capture scale
      4'd3:    word = {8'b0010_0010, 4'd4};  // R3 <= R3 * R4
      4'd4:    word = {8'b0000_0001, IDLE_ADDR};  // signal completion
      default: word = {8'b0000_0000, IDLE_ADDR};  // idle loops on itself
    endcase
  end
endmodule

// File: rtl/ucsm_seq.sv
module ucsm_seq
  import ucsm_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic [AW-1:0] nxt,
  output logic [AW-1:0] pc,
  output logic          idle
);
  assign idle = (pc == IDLE_ADDR);

  always_ff @(posedge clk) begin
    if (rst)              pc <= IDLE_ADDR;
    else if (idle && go)  pc <= ENTRY_ADDR;
    else                  pc <= nxt;
  end
endmodule

// File: rtl/ucsm_dpath.sv
module ucsm_dpath
  import ucsm_pkg::*;
#(
  parameter int DW = 8,
  localparam int RW = 2*DW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  ctl_t          ctl,
  input  logic [DW-1:0] opa,
  input  logic [DW-1:0] opb,
  input  logic [DW-1:0] ope,
  output logic [RW-1:0] r3
);
  logic [DW-1:0] r1, r2, r4;
  logic [DW:0]   sum;
  logic [RW-1:0] prod, r3_d;

  always_comb begin
    sum  = ctl.add_en ? ({1'b0, r1} + {1'b0, r2}) : '0;
    prod = ctl.mul_en ? (r3 * RW'(r4)) : '0;
    r3_d = ctl.sel_add ? {{(RW-DW-1){1'b0}}, sum} : prod;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      r1 <= '0;
      r2 <= '0;
      r3 <= '0;
      r4 <= '0;
    end else begin
      if (ctl.ld_r1) r1 <= opa;
      if (ctl.ld_r2) r2 <= opb;
      if (ctl.ld_r3) r3 <= r3_d;
      if (ctl.ld_r4) r4 <= ope;
    end
  end
endmodule

// File: rtl/ucsm_top.sv
module ucsm_top
  import ucsm_pkg::*;
#(
  parameter int DW = 8,
  localparam int RW = 2*DW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_a,
  input  logic [DW-1:0] in_b,
  input  logic [DW-1:0] in_e,
  output logic          out_valid,
  output logic [RW-1:0] out_result
);
  logic [AW-1:0] pc;
  logic          idle;
  uword_t        word;
  logic [DW-1:0] cap_a, cap_b, cap_e;
  logic [RW-1:0] r3_q;
  logic          mul_en;
  logic          take;

  assign take = in_valid && idle;

  ucsm_seq u_seq (
    .clk(clk), .rst(rst), .go(in_valid), .nxt(word.nxt),
    .pc(pc), .idle(idle)
  );

  ucsm_rom u_rom (.addr(pc), .word(word));

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_a <= '0;
      cap_b <= '0;
      cap_e <= '0;
    end else if (take) begin
      cap_a <= in_a;
      cap_b <= in_b;
      cap_e <= in_e;
    end
  end

  ucsm_dpath #(.DW(DW)) u_dp (
    .clk(clk), .rst(rst), .ctl(word.ctl),
    .opa(cap_a), .opb(cap_b), .ope(cap_e), .r3(r3_q)
  );

  assign mul_en     = word.ctl.mul_en;
  assign in_ready   = idle;
  assign out_valid  = word.ctl.done;
  assign out_result = r3_q;
endmodule

// File: rtl/ucsm_top_chk.sv
module ucsm_top_chk #(
  parameter int DW = 8,
  localparam int RW = 2*DW + 1
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic          in_ready,
  input logic          out_valid,
  input logic [RW-1:0] out_result,
  input logic          mul_en,
  input logic [RW-1:0] r3
);
  // R2: an accepted triple makes the unit busy
  p_accept_busy: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> !in_ready);

  // R2/R3: completion never coincides with idle
  p_done_not_idle: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !in_ready);

  // R3: completion pulse is one cycle wide
  p_done_single: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  // R6: idle right after completion
  p_idle_after_done: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> in_ready);

  // R8: result frozen while idle and no offer
  p_hold_result: assert property (@(posedge clk) disable iff (rst)
    (in_ready && !in_valid) |=> $stable(out_result));

  // R7: no completion from an idle wait
  p_no_spurious_done: assert property (@(posedge clk) disable iff (rst)
    (in_ready && !in_valid) |=> !out_valid);

  // R4: the multiplicand in R3 fits in the sum width, so the product cannot wrap
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    mul_en |-> (r3[RW-1:DW+1] == '0));
endmodule

bind ucsm_top ucsm_top_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_result(out_result),
  .mul_en(mul_en), .r3(r3_q)
);

// File: tb/ucsm_top_test.sv
module ucsm_top_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [7:0]  in_a = '0, in_b = '0, in_e = '0;
  logic        in_ready, out_valid;
  logic [16:0] out_result;

  int n_chk = 0;
  int n_err = 0;
  int unsigned exp_q[$];
  bit done_flag = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  ucsm_top uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .in_e(in_e),
    .out_valid(out_valid), .out_result(out_result)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // scoreboard monitor: R4 value on each completion pulse
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && out_valid) begin
        if (exp_q.size() == 0) chk(1'b0, "R7 unexpected out_valid", 1, 0);
        else begin
          int unsigned e;
          e = exp_q.pop_front();
          chk(out_result == 17'(e), "R4 product", int'(out_result), int'(e));
        end
      end
    end
  end

  // driver: one operation, with timing checks, scrambled operands while busy
  task automatic run_op(input logic [7:0] a, input logic [7:0] b, input logic [7:0] e);
    int sum_v;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1; in_a = a; in_b = b; in_e = e;
    sum_v = int'(a) + int'(b);
    exp_q.push_back(int'(e) * sum_v);
    @(negedge clk);  // accepting edge has passed
    chk(in_ready == 1'b0, "R2 busy after accept", int'(in_ready), 0);
    in_a = ~a; in_b = ~b; in_e = ~e;  // R5 and R2: must be ignored
    @(negedge clk);
    @(negedge clk);
    chk(out_result == 17'(sum_v), "R9 sum in shared reg", int'(out_result), sum_v);
    @(negedge clk);
    chk(out_valid == 1'b0, "R3 not early", int'(out_valid), 0);
    in_valid = 1'b0;
    @(negedge clk);
    chk(out_valid == 1'b1, "R3 pulse on 4th edge", int'(out_valid), 1);
    @(negedge clk);
    chk(out_valid == 1'b0, "R3 single cycle", int'(out_valid), 0);
    chk(in_ready == 1'b1, "R6 idle after done", int'(in_ready), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(in_ready == 1'b1, "R1 ready after reset", int'(in_ready), 1);
    chk(out_valid == 1'b0, "R1 no done after reset", int'(out_valid), 0);
    chk(out_result == '0, "R1 result cleared", int'(out_result), 0);

    run_op(8'd3, 8'd4, 8'd5);
    run_op(8'd0, 8'd0, 8'd77);
    run_op(8'd200, 8'd100, 8'd1);   // carry into bit 8
    run_op(8'd255, 8'd255, 8'd255); // R4 maximum 130050
    run_op(8'd9, 8'd0, 8'd0);
    for (int i = 0; i < 20; i++)
      run_op(8'($urandom), 8'($urandom), 8'($urandom));

    // R7 and R8: idle without an offer
    begin
      logic [16:0] held;
      held = out_result;
      for (int i = 0; i < 6; i++) begin
        @(negedge clk);
        chk(out_result == held, "R8 result held in idle", int'(out_result), int'(held));
        chk(out_valid == 1'b0, "R7 no pulse in idle", int'(out_valid), 0);
      end
    end

    run_op(8'd1, 8'd1, 8'd128);
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R3 every accept completed", exp_q.size(), 0);

    done_flag = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done_flag) begin
      n_chk++;
      n_err++;
      $display("FAIL R3 watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule